// File: doc/BRIEF.md
# Interconnect Performance Monitor Unit

This block counts traffic activity inside a coherent interconnect. It holds one cycle counter and a parameterised number of 32-bit event counters, four by default. Each counter is reached through its own page on a simple register bus. Elsewhere, the interconnect produces one single-cycle pulse per event type and per source port. Software picks which pulse each event counter follows, turns counters on one by one, and then starts or stops them all through one global control register.

The selector is a byte. Its upper three bits name a source port: values 0 to 4 are slave ports and values 5 to 7 are master ports. Its lower five bits name the event code. The event pulse input is a flat vector indexed by `source*32 + code`. When a counter wraps, it sets a sticky flag. That flag drives the counter's own interrupt line until software writes 1 to clear it.

Register layout: the global control register is at 0x100. Counter page k, with k = 0 for the cycle counter and k = 1..4 for the event counters, starts at 0x9000 + k*0x1000. Inside a page, the selector is at +0x0, the count at +0x4, the per-counter enable (bit 0) at +0x8 and the overflow flag (bit 0) at +0xC. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `icn_perfmon`

## Requirements
- R1: Reset clears every count, selector, per-counter enable, overflow flag and interrupt. The global control register then reads 0x2000, which is the event counter count (4) in bits 15:11 with bit 0 clear.
- R2: No counter changes while global enable (control bit 0) is clear.
- R3: An event counter whose selector names a slave port (0..4) with a code in 0x00..0x13 adds exactly 1 on each clock where that pulse is high and both enables are set.
- R4: A selector that names a master port (5..7) with a code in 0x14..0x1A counts its pulse in the same way.
- R5: Any other source/code combination never increments the counter, even when the pulse at that index is high.
- R6: The cycle counter adds 1 on every clock where it and the global enable are both set. It ignores its selector and the event pulses.
- R7: A count wraps from 0xFFFFFFFF to 0. The wrap sets that counter's overflow flag, bit 0 of page offset 0xC, and the matching `ovf_irq` bit stays high while the flag is set.
- R8: Writing 1 to overflow bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R9: A write to the count register loads the written value, and it wins over an increment in the same cycle.
- R10: Writing control bit 1 zeroes every count, and writing control bit 2 zeroes only the cycle counter. Both bits read back as 0.
- R11: An event counter with its page enable bit (offset 0x8, bit 0) clear does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_pulse | input | 256 | Event pulses, index source*32+code |
| ovf_irq | output | 5 | Overflow interrupt per counter, bit 0 = cycle counter |

## Verification
The assertions assume three things about the bus. Only one register is touched per cycle, so a count write and a reset strobe never hit the same counter together. Event pulses last a single cycle. Writes change state only at the edge where `bus_we` is high. The stimulus keeps to these rules: each write and each pulse is held for exactly one edge, and the global enable is cleared before counts are read back, so the values seen on `bus_rdata` do not move while the scoreboard compares them.

// File: rtl/icn_perfmon_pkg.sv
// Package: shared constants for the interconnect performance monitor.
// Assumes an 8-bit selector split as {source[2:0], code[4:0]}.
package icn_perfmon_pkg;
    localparam int SEL_W        = 8;
    localparam int SRC_W        = 3;
    localparam int CODE_W       = 5;
    localparam int SLV_SRC_MAX  = 4;
    localparam int SLV_CODE_MAX = 19;
    localparam int MST_CODE_MIN = 20;
    localparam int MST_CODE_MAX = 26;
    localparam logic [15:0] CTRL_ADDR = 16'h0100;
    localparam logic [3:0]  PAGE_NIB0 = 4'h9;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RSTALL  = 1;
    localparam int CTRL_RSTCYC  = 2;
    localparam int CTRL_NUM_LSB = 11;

    typedef enum logic [1:0] {
        PG_SEL = 2'd0,
        PG_CNT = 2'd1,
        PG_CTL = 2'd2,
        PG_OVF = 2'd3
    } page_reg_e;
endpackage

// File: rtl/pm_event_filter.sv
// Event filter: checks a selector against the legal slave/master code
// ranges and picks the matching event pulse.
// Assumes ev_pulse is indexed by the full selector value.
module pm_event_filter
    import icn_perfmon_pkg::*;
#(
    parameter int NUM_EV = 256
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_EV-1:0] ev_pulse,
    output logic              legal,
    output logic              hit
);
    logic [SRC_W-1:0]  src;
    logic [CODE_W-1:0] code;

    // Range check on the source port and event code fields
    always_comb begin
        src   = sel[SEL_W-1 -: SRC_W];
        code  = sel[CODE_W-1:0];
        if (32'(src) <= SLV_SRC_MAX)
            legal = (32'(code) <= SLV_CODE_MAX);
        else
            legal = (32'(code) >= MST_CODE_MIN) && (32'(code) <= MST_CODE_MAX);
        hit = legal && ev_pulse[sel];
    end
endmodule

// File: rtl/pm_counter.sv
// One monitor counter with its register page: selector, count, enable
// and sticky overflow flag. IS_CYCLE picks the cycle-counter variant,
// which counts every clock. Assumes at most one register write per cycle.
module pm_counter
    import icn_perfmon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_EV   = 256,
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              global_en,
    input  logic              wr_sel,
    input  logic              wr_cnt,
    input  logic              wr_ctl,
    input  logic              wr_ovf,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              zero_cnt,
    input  logic [NUM_EV-1:0] ev_pulse,
    output logic [SEL_W-1:0]  sel_q,
    output logic [CNT_W-1:0]  count,
    output logic              en_q,
    output logic              ovf_q,
    output logic              irq
);
    logic hit;
    logic legal;
    logic inc;
    logic wrap;

    generate
        if (IS_CYCLE) begin : g_cycle
            assign hit   = 1'b1;
            assign legal = 1'b1;
        end else begin : g_event
            pm_event_filter #(.NUM_EV(NUM_EV)) u_filter (
                .sel      (sel_q),
                .ev_pulse (ev_pulse),
                .legal    (legal),
                .hit      (hit)
            );
        end
    endgenerate

    // Increment and wrap conditions for this cycle
    always_comb begin
        inc  = global_en && en_q && hit;
        wrap = inc && !wr_cnt && !zero_cnt && (count == {CNT_W{1'b1}});
    end

    // Page registers and count update, reset-zero first, then write, then increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            count <= '0;
            en_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_sel) sel_q <= wdata[SEL_W-1:0];
            if (wr_ctl) en_q  <= wdata[0];
            if (zero_cnt)    count <= '0;
            else if (wr_cnt) count <= wdata;
            else if (inc)    count <= count + 1'b1;
            if (wrap)                    ovf_q <= 1'b1;
            else if (wr_ovf && wdata[0]) ovf_q <= 1'b0;
        end
    end

    assign irq = ovf_q;

    // R2: frozen while the global enable is clear
    p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!global_en && !wr_cnt && !zero_cnt) |=> $stable(count));
    // R3: at most one step per clock
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !zero_cnt) |=> (count == $past(count) || count == $past(count) + 1'b1));
    // R5: illegal selector never counts
    p_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!legal && !wr_cnt && !zero_cnt) |=> $stable(count));
    // R6: cycle counter runs every enabled clock
    p_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_CYCLE && global_en && en_q && !wr_cnt && !zero_cnt) |=> count == $past(count) + 1'b1);
    // R7: wrap lands at zero with the flag set
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == {CNT_W{1'b1}} && !wr_cnt && !zero_cnt) |=> (ovf_q && count == '0));
    // R8: flag is sticky until a write of 1
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_ovf && wdata[0])) |=> ovf_q);
    // R9: written value wins
    p_wrprio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !zero_cnt) |=> count == $past(wdata));
    // R10: reset strobe zeroes the count
    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cnt |=> count == '0);
    // R11: disabled counter holds
    p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_cnt && !zero_cnt) |=> $stable(count));
endmodule

// File: rtl/icn_perfmon.sv
// Interconnect performance monitor top: register decode, global control
// and read mux around one cycle counter and NUM_EVT_CNT event counters.
// Assumes a 16-bit byte address, word-aligned accesses, and one access per cycle.
module icn_perfmon
    import icn_perfmon_pkg::*;
#(
    parameter int NUM_EVT_CNT = 4,
    parameter int CNT_W       = 32,
    parameter int NUM_SRC     = 8,
    parameter int NUM_CODE    = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [15:0]                            bus_addr,
    input  logic                                   bus_we,
    input  logic [CNT_W-1:0]                       bus_wdata,
    output logic [CNT_W-1:0]                       bus_rdata,
    input  logic [NUM_SRC*NUM_CODE-1:0]            ev_pulse,
    output logic [NUM_EVT_CNT:0]                   ovf_irq
);
    localparam int NUM_CNT = NUM_EVT_CNT + 1;
    localparam int NUM_EV  = NUM_SRC * NUM_CODE;

    logic             global_en;
    logic             ctrl_hit;
    logic             page_hit;
    logic [3:0]       page_idx;
    page_reg_e        page_reg;
    logic             rst_all;
    logic             rst_cyc;
    logic [SEL_W-1:0] sel_q [NUM_CNT];
    logic [CNT_W-1:0] cnt_q [NUM_CNT];
    logic             en_q  [NUM_CNT];
    logic             ovf_q [NUM_CNT];

    // Address decode for the control register and counter pages
    always_comb begin
        ctrl_hit = (bus_addr == CTRL_ADDR);
        page_idx = bus_addr[15:12] - PAGE_NIB0;
        page_hit = (bus_addr[15:12] >= PAGE_NIB0) && (32'(page_idx) < NUM_CNT)
                   && (bus_addr[11:4] == 8'h00) && (bus_addr[1:0] == 2'b00);
        page_reg = page_reg_e'(bus_addr[3:2]);
        rst_all  = bus_we && ctrl_hit && bus_wdata[CTRL_RSTALL];
        rst_cyc  = bus_we && ctrl_hit && bus_wdata[CTRL_RSTCYC];
    end

    // Global enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                 global_en <= 1'b0;
        else if (bus_we && ctrl_hit) global_en <= bus_wdata[CTRL_EN_BIT];
    end

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic sel_me;
            assign sel_me = bus_we && page_hit && (page_idx == 4'(i));
            pm_counter #(
                .CNT_W    (CNT_W),
                .NUM_EV   (NUM_EV),
                .IS_CYCLE (i == 0)
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .global_en (global_en),
                .wr_sel    (sel_me && page_reg == PG_SEL),
                .wr_cnt    (sel_me && page_reg == PG_CNT),
                .wr_ctl    (sel_me && page_reg == PG_CTL),
                .wr_ovf    (sel_me && page_reg == PG_OVF),
                .wdata     (bus_wdata),
                .zero_cnt  (rst_all || (i == 0 && rst_cyc)),
                .ev_pulse  (ev_pulse),
                .sel_q     (sel_q[i]),
                .count     (cnt_q[i]),
                .en_q      (en_q[i]),
                .ovf_q     (ovf_q[i]),
                .irq       (ovf_irq[i])
            );
        end
    endgenerate

    // Combinational read mux; strobe bits always read as zero
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata[CTRL_EN_BIT] = global_en;
            bus_rdata[CTRL_NUM_LSB +: 5] = 5'(NUM_EVT_CNT);
        end else if (page_hit) begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (page_idx == 4'(i)) begin
                    case (page_reg)
                        PG_SEL:  bus_rdata[SEL_W-1:0] = sel_q[i];
                        PG_CNT:  bus_rdata = cnt_q[i];
                        PG_CTL:  bus_rdata[0] = en_q[i];
                        default: bus_rdata[0] = ovf_q[i];
                    endcase
                end
            end
        end
    end
endmodule

// File: tb/icn_perfmon_tb.sv
// Scoreboard bench: read tasks queue expected values, a negedge monitor
// pops and compares them against bus_rdata.
module icn_perfmon_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [255:0] ev_pulse = '0;
    logic [4:0]  ovf_irq;
    logic        rd_req = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    typedef struct { logic [31:0] exp; string tag; } rd_item_t;
    rd_item_t sb_q[$];
    rd_item_t cur;

    icn_perfmon u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pulse(ev_pulse), .ovf_irq(ovf_irq)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] pg(int k, int ofs);
        return 16'(32'h9000 + k * 32'h1000 + ofs);
    endfunction

    // Monitor: pop and compare on each read
    always @(negedge clk) begin
        if (rd_req) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                cur = sb_q.pop_front();
                if (bus_rdata !== cur.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", cur.tag, bus_rdata, cur.exp);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // All tasks start and end just after a rising edge
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic pulses(input int idx, input int n);
        repeat (n) begin
            ev_pulse = '0; ev_pulse[idx] = 1'b1;
            @(posedge clk); #1;
        end
        ev_pulse = '0;
    endtask

    task automatic chk_irq(input logic [4:0] exp, input string tag);
        @(negedge clk);
        n_checks++;
        if (ovf_irq !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, ovf_irq, exp);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(16'h0100, 32'h2000, "R1 ctrl");
        rd(pg(0, 4), 0, "R1 cycle count");
        rd(pg(1, 4), 0, "R1 count1");
        rd(pg(1, 0), 0, "R1 sel1");
        rd(pg(2, 12), 0, "R1 ovf2");
        chk_irq(5'b0, "R1 irq");

        // R2 global disabled: no counting
        wr(pg(1, 0), 32'h03);
        wr(pg(1, 8), 1);
        pulses(3, 5);
        rd(pg(1, 4), 0, "R2 gated");

        // R3 slave-port event
        wr(16'h0100, 1);
        pulses(3, 5);
        wr(16'h0100, 0);
        rd(pg(1, 4), 5, "R3 slave count");

        // R4 master-port events, boundaries 0x14 and 0x1A
        wr(pg(2, 0), 32'hB4);
        wr(pg(2, 8), 1);
        wr(pg(3, 0), 32'hFA);
        wr(pg(3, 8), 1);
        wr(16'h0100, 1);
        pulses(180, 3);
        pulses(250, 4);
        wr(16'h0100, 0);
        rd(pg(2, 4), 3, "R4 master 0x14");
        rd(pg(3, 4), 4, "R4 master 0x1A");

        // R5 illegal combinations: slave with 0x14, master with 0x05
        wr(pg(4, 0), 32'h14);
        wr(pg(4, 8), 1);
        wr(16'h0100, 1);
        pulses(20, 3);
        wr(16'h0100, 0);
        rd(pg(4, 4), 0, "R5 slave code 0x14");
        wr(pg(4, 0), 32'hC5);
        wr(16'h0100, 1);
        pulses(197, 2);
        wr(16'h0100, 0);
        rd(pg(4, 4), 0, "R5 master code 0x05");
        rd(pg(1, 4), 5, "R5 other counter untouched");

        // R11 per-counter enable off
        wr(pg(1, 8), 0);
        wr(16'h0100, 1);
        pulses(3, 2);
        wr(16'h0100, 0);
        rd(pg(1, 4), 5, "R11 disabled");

        // R6 cycle counter, selector ignored, no pulses: 11 edges enabled
        wr(pg(0, 0), 32'h55);
        wr(pg(0, 8), 1);
        wr(16'h0100, 1);
        repeat (10) @(posedge clk);
        #1;
        wr(16'h0100, 0);
        rd(pg(0, 4), 11, "R6 cycle count");

        // R7 wrap: FFFFFFFE + 3 -> 1 with flag
        wr(pg(1, 8), 1);
        wr(pg(1, 4), 32'hFFFF_FFFE);
        wr(16'h0100, 1);
        pulses(3, 3);
        wr(16'h0100, 0);
        rd(pg(1, 4), 1, "R7 wrapped count");
        rd(pg(1, 12), 1, "R7 flag");
        chk_irq(5'b00010, "R7 irq");

        // R8 write 0 keeps, write 1 clears
        wr(pg(1, 12), 0);
        rd(pg(1, 12), 1, "R8 write0 keeps");
        wr(pg(1, 12), 1);
        rd(pg(1, 12), 0, "R8 write1 clears");
        chk_irq(5'b0, "R8 irq low");

        // R9 write wins over simultaneous increment
        wr(16'h0100, 1);
        ev_pulse = '0; ev_pulse[3] = 1'b1;
        wr(pg(1, 4), 100);
        ev_pulse = '0;
        wr(16'h0100, 0);
        rd(pg(1, 4), 100, "R9 write priority");

        // R10 cycle reset strobe then reset-all strobe
        wr(16'h0100, 32'h4);
        rd(pg(0, 4), 0, "R10 cycle zeroed");
        rd(pg(1, 4), 100, "R10 event kept");
        rd(16'h0100, 32'h2000, "R10 strobe reads 0");
        wr(16'h0100, 32'h2);
        rd(pg(1, 4), 0, "R10 all zero c1");
        rd(pg(2, 4), 0, "R10 all zero c2");
        rd(pg(3, 4), 0, "R10 all zero c3");
        rd(16'h0100, 32'h2000, "R10 ctrl readback");

        @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule